// File: doc/BRIEF.md
# Selectable-Ratio Clock Divider

This block turns one fast source clock into three families of derived clocks: a CPU clock, a PCI clock and a reference clock. Each family goes to a parameterised number of identical copies. A two-bit select input chooses one of four operating modes. Two modes are active modes with a fixed CPU-to-PCI frequency ratio of 2 or 3. One is a test mode with fixed division factors. The last is an off mode that releases every output to high impedance.

Each output is modelled as a registered clock level plus a shared output-enable flag. Every divider restarts on the same source edge, so each rising edge of the PCI clock falls on a rising edge of the CPU clock and of the reference clock. A new select code is taken only when the PCI phase wraps, which keeps every pulse at full length.

Time is counted in source cycles. One source cycle is half a period of the modelled source, so a divide-by-N output has a period of 2N cycles. With the default parameters, low-speed mode gives CPU 6 / PCI 12, high-speed mode gives CPU 4 / PCI 12, and test mode gives CPU 4 / PCI 12 / reference 2. In every mode except test, the reference period is REF_PERIOD. Each output is high for the first (period+1)/2 cycles of its period and low for the rest.

Top module: `ratio_clock_divider`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, after that edge every clock output is 0 and `clk_oe` is 1.
- R2: At the first rising edge with `rst_n` high, `mode_sel` is taken and every clock output starts its period, so all of them are 1 after that edge.
- R3: With `mode_sel` = 2'b01 (low speed), the PCI period is PCI_PERIOD cycles and the CPU period is PCI_PERIOD/2, giving two CPU rising edges per PCI period.
- R4: With `mode_sel` = 2'b11 (high speed), the PCI period is PCI_PERIOD and the CPU period is PCI_PERIOD/3. Every output is high for the first (period+1)/2 cycles of its period.
- R5: With `mode_sel` = 2'b10 (test), the CPU period is 4 cycles, the PCI period is 12 cycles and the reference period is 2 cycles, whatever the parameters.
- R6: `clk_oe` is 0 exactly while mode 2'b00 (off) is applied and 1 in every other mode. The dividers keep running while it is 0.
- R7: In modes 2'b00, 2'b01 and 2'b11 the reference period is REF_PERIOD, unaffected by which of these modes is applied.
- R8: Every rising edge of the PCI clock coincides with a rising edge of the CPU clock and of the reference clock.
- R9: A change of `mode_sel` takes effect only at the edge where the PCI phase of the applied mode wraps to zero. No period is cut short.
- R10: All copies of the CPU clock carry identical values, and so do all copies of the PCI clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; one cycle is half a modelled source period |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Mode select: 00 off, 01 low speed, 11 high speed, 10 test |
| cpu_clk | output | NUM_CPU | CPU clock copies |
| pci_clk | output | NUM_PCI | PCI clock copies |
| ref_clk | output | 1 | Reference clock |
| clk_oe | output | 1 | Output enable shared by all clock outputs; 0 means high impedance |

## Verification
Each of the four select codes is held from reset. This separates the ratio-2 CPU period from the ratio-3 CPU period and from the fixed test divisors, and shows that the reference period stays the same across the off and active modes. The select code is also changed mid-period, once per mode pair. These runs show whether a new code waits for the PCI wrap or cuts a pulse short. A reset issued in the middle of a run checks that all outputs are forced low with the enable held high. Counting rising edges over whole PCI periods tells a wrong divider apart from a correct one that is misaligned.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_LO   = 2'b01,
      MODE_TEST = 2'b10,
      MODE_HI   = 2'b11
   } rcd_mode_e;

   // fixed test-mode periods in source cycles (half periods of the source)
   localparam int TEST_CPU_PER = 4;
   localparam int TEST_PCI_PER = 12;
   localparam int TEST_REF_PER = 2;

   function automatic int pci_period(rcd_mode_e m, int pci_p);
      return (m == MODE_TEST) ? TEST_PCI_PER : pci_p;
   endfunction

   function automatic int cpu_period(rcd_mode_e m, int pci_p);
      case (m)
         MODE_TEST: return TEST_CPU_PER;
         MODE_HI:   return pci_p / 3;
         default:   return pci_p / 2;
      endcase
   endfunction

   function automatic int ref_period(rcd_mode_e m, int ref_p);
      return (m == MODE_TEST) ? TEST_REF_PER : ref_p;
   endfunction

endpackage

// File: rtl/rcd_mode_ctrl.sv
module rcd_mode_ctrl
   import rcd_pkg::*;
#(
   parameter int PCI_PERIOD = 12,
   parameter int CW         = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode_sel,
   output logic            boundary,
   output rcd_mode_e       mode_next,
   output logic            oe_q
);

   logic            started_q;
   rcd_mode_e       mode_q;
   logic [CW-1:0]   phase_q;
   logic [CW-1:0]   phase_last;
   logic            phase_end;

   assign phase_last = CW'(pci_period(mode_q, PCI_PERIOD) - 1);
   assign phase_end  = (phase_q == phase_last);
   assign boundary   = !started_q || phase_end;
   assign mode_next  = boundary ? rcd_mode_e'(mode_sel) : mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started_q <= 1'b0;
         mode_q    <= MODE_LO;
         phase_q   <= '0;
         oe_q      <= 1'b1;
      end else begin
         started_q <= 1'b1;
         mode_q    <= mode_next;
         phase_q   <= boundary ? '0 : phase_q + 1'b1;
         oe_q      <= (mode_next != MODE_OFF);
      end
   end

   // R9: mode register only moves on a wrap
   assert_mode_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && !phase_end) |=> $stable(mode_q));

   // R9: phase never runs past the applied period
   assert_phase_bound_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      started_q |-> (phase_q <= phase_last));

endmodule

// File: rtl/rcd_divider.sv
module rcd_divider #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [CW-1:0] period,
   output logic          clk_q
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_next;
   logic [CW-1:0] high_len;

   assign high_len = (period + 1'b1) >> 1;

   always_comb begin
      if (restart || (cnt_q == period - 1'b1))
         cnt_next = '0;
      else
         cnt_next = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         clk_q <= 1'b0;
      end else begin
         cnt_q <= cnt_next;
         clk_q <= (cnt_next < high_len);
      end
   end

   // R4: each period opens with the high phase
   assert_high_first_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> clk_q);

endmodule

// File: rtl/rcd_fanout.sv
module rcd_fanout #(
   parameter int N = 2
) (
   input  logic         src,
   output logic [N-1:0] dst
);

   for (genvar i = 0; i < N; i++) begin : g_copy
      assign dst[i] = src;
   end

endmodule

// File: rtl/ratio_clock_divider.sv
module ratio_clock_divider
   import rcd_pkg::*;
#(
   parameter int NUM_CPU    = 2,
   parameter int NUM_PCI    = 5,
   parameter int PCI_PERIOD = 12,
   parameter int REF_PERIOD = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_sel,
   output logic [NUM_CPU-1:0] cpu_clk,
   output logic [NUM_PCI-1:0] pci_clk,
   output logic               ref_clk,
   output logic               clk_oe
);

   localparam int MAX_PER = (PCI_PERIOD > TEST_PCI_PER) ? PCI_PERIOD : TEST_PCI_PER;
   localparam int CW      = $clog2(MAX_PER) + 1;

   initial begin
      assert (PCI_PERIOD >= 6 && PCI_PERIOD % 6 == 0)
         else $fatal(1, "PCI_PERIOD must be a positive multiple of 6");
      assert (REF_PERIOD >= 2 && PCI_PERIOD % REF_PERIOD == 0)
         else $fatal(1, "REF_PERIOD must be at least 2 and divide PCI_PERIOD");
      assert (NUM_CPU >= 1 && NUM_PCI >= 1)
         else $fatal(1, "at least one copy of each clock is needed");
   end

   logic            boundary;
   rcd_mode_e       mode_next;
   logic [CW-1:0]   cpu_per;
   logic [CW-1:0]   pci_per;
   logic [CW-1:0]   ref_per;
   logic            cpu_int;
   logic            pci_int;
   logic            ref_int;

   assign cpu_per = CW'(cpu_period(mode_next, PCI_PERIOD));
   assign pci_per = CW'(pci_period(mode_next, PCI_PERIOD));
   assign ref_per = CW'(ref_period(mode_next, REF_PERIOD));

   rcd_mode_ctrl #(.PCI_PERIOD(PCI_PERIOD), .CW(CW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .boundary  (boundary),
      .mode_next (mode_next),
      .oe_q      (clk_oe)
   );

   rcd_divider #(.CW(CW)) u_cpu_div (
      .clk (clk), .rst_n (rst_n), .restart (boundary), .period (cpu_per), .clk_q (cpu_int)
   );

   rcd_divider #(.CW(CW)) u_pci_div (
      .clk (clk), .rst_n (rst_n), .restart (boundary), .period (pci_per), .clk_q (pci_int)
   );

   rcd_divider #(.CW(CW)) u_ref_div (
      .clk (clk), .rst_n (rst_n), .restart (boundary), .period (ref_per), .clk_q (ref_int)
   );

   rcd_fanout #(.N(NUM_CPU)) u_cpu_fan (.src (cpu_int), .dst (cpu_clk));
   rcd_fanout #(.N(NUM_PCI)) u_pci_fan (.src (pci_int), .dst (pci_clk));
   assign ref_clk = ref_int;

   // R8: PCI rising edges land on CPU and reference rising edges
   assert_pci_on_cpu_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pci_int) |-> $rose(cpu_int));
   assert_ref_on_pci_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pci_int) |-> $rose(ref_int));

   // R6: enable only toggles at the start of a PCI period
   assert_oe_at_wrap_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk_oe) |-> pci_int);

   // R1: reset state seen after a reset edge
   logic rst_seen_q;
   always_ff @(posedge clk) rst_seen_q <= !rst_n;
   always @(negedge clk) begin
      if (rst_seen_q) begin
         assert_reset_state_R1 : assert (cpu_int == 1'b0 && pci_int == 1'b0 &&
                                         ref_int == 1'b0 && clk_oe == 1'b1);
      end
   end

endmodule

// File: tb/ratio_clock_divider_test.sv
module ratio_clock_divider_test;

   localparam int NC = 2;
   localparam int NP = 5;
   localparam int PP = 12;
   localparam int RP = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_sel = 2'b01;
   logic [NC-1:0] cpu_clk;
   logic [NP-1:0] pci_clk;
   logic          ref_clk;
   logic          clk_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ratio_clock_divider #(.NUM_CPU(NC), .NUM_PCI(NP), .PCI_PERIOD(PP), .REF_PERIOD(RP)) uut (
      .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel),
      .cpu_clk (cpu_clk), .pci_clk (pci_clk), .ref_clk (ref_clk), .clk_oe (clk_oe)
   );

   // periods taken from the requirements
   function automatic int pp_of(logic [1:0] m);
      return (m == 2'b10) ? 12 : PP;
   endfunction
   function automatic int cp_of(logic [1:0] m);
      if (m == 2'b10) return 4;
      if (m == 2'b11) return PP / 3;
      return PP / 2;
   endfunction
   function automatic int rp_of(logic [1:0] m);
      return (m == 2'b10) ? 2 : RP;
   endfunction

   // expected-state tracker
   bit         m_rst = 1'b1;
   bit         m_started = 1'b0;
   logic [1:0] m_mode = 2'b01;
   int         m_idx = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rst = 1'b1; m_started = 1'b0; m_idx = 0;
      end else begin
         m_rst = 1'b0;
         if (!m_started || m_idx == pp_of(m_mode) - 1) begin
            m_mode = mode_sel; m_idx = 0; m_started = 1'b1;
         end else begin
            m_idx = m_idx + 1;
         end
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   int  cpu_rises, pci_rises, ref_rises;
   logic p_cpu = 1'b0, p_pci = 1'b0, p_ref = 1'b0;

   task automatic clear_counts();
      cpu_rises = 0; pci_rises = 0; ref_rises = 0;
   endtask

   task automatic sample_all(string req);
      logic e_cpu, e_pci, e_ref, e_oe;
      if (m_rst) begin
         e_cpu = 1'b0; e_pci = 1'b0; e_ref = 1'b0; e_oe = 1'b1;
      end else begin
         e_cpu = (m_idx % cp_of(m_mode)) < (cp_of(m_mode) + 1) / 2;
         e_pci = (m_idx % pp_of(m_mode)) < (pp_of(m_mode) + 1) / 2;
         e_ref = (m_idx % rp_of(m_mode)) < (rp_of(m_mode) + 1) / 2;
         e_oe  = (m_mode != 2'b00);
      end
      chk(cpu_clk[0] == e_cpu, req, "cpu_clk", int'(cpu_clk[0]), int'(e_cpu));
      chk(pci_clk[0] == e_pci, req, "pci_clk", int'(pci_clk[0]), int'(e_pci));
      chk(ref_clk == e_ref, req, "ref_clk", int'(ref_clk), int'(e_ref));
      chk(clk_oe == e_oe, req, "clk_oe", int'(clk_oe), int'(e_oe));
      // R10: copies match
      chk(cpu_clk == {NC{cpu_clk[0]}}, "R10", "cpu copies", int'(cpu_clk), int'({NC{cpu_clk[0]}}));
      chk(pci_clk == {NP{pci_clk[0]}}, "R10", "pci copies", int'(pci_clk), int'({NP{pci_clk[0]}}));
      if (pci_clk[0] && !p_pci) begin
         // R8: PCI rise on CPU and reference rise
         chk(cpu_clk[0] && !p_cpu, "R8", "cpu rise with pci rise", int'(cpu_clk[0] && !p_cpu), 1);
         chk(ref_clk && !p_ref, "R8", "ref rise with pci rise", int'(ref_clk && !p_ref), 1);
      end
      if (cpu_clk[0] && !p_cpu) cpu_rises++;
      if (pci_clk[0] && !p_pci) pci_rises++;
      if (ref_clk && !p_ref) ref_rises++;
      p_cpu = cpu_clk[0]; p_pci = pci_clk[0]; p_ref = ref_clk;
   endtask

   task automatic run(int n, string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sample_all(req);
      end
   endtask

   task automatic do_reset(logic [1:0] m);
      @(negedge clk);
      rst_n = 1'b0;
      mode_sel = m;
      run(3, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_clk[0] && pci_clk[0] && ref_clk, "R2", "all high after release",
          int'({cpu_clk[0], pci_clk[0], ref_clk}), 7);
      sample_all("R2");
      clear_counts();
   endtask

   task automatic t_low();
      do_reset(2'b01);
      run(PP * 4, "R3");
      chk(cpu_rises == 8, "R3", "cpu rises in 4 pci periods", cpu_rises, 8);
      chk(pci_rises == 4, "R3", "pci rises", pci_rises, 4);
      chk(ref_rises == 4 * PP / RP, "R7", "ref rises low speed", ref_rises, 4 * PP / RP);
   endtask

   task automatic t_high();
      do_reset(2'b11);
      run(PP * 4, "R4");
      chk(cpu_rises == 12, "R4", "cpu rises in 4 pci periods", cpu_rises, 12);
      chk(pci_rises == 4, "R4", "pci rises", pci_rises, 4);
      chk(ref_rises == 4 * PP / RP, "R7", "ref rises high speed", ref_rises, 4 * PP / RP);
   endtask

   task automatic t_test();
      do_reset(2'b10);
      run(48, "R5");
      chk(cpu_rises == 12, "R5", "cpu rises in 48 cycles", cpu_rises, 12);
      chk(pci_rises == 4, "R5", "pci rises in 48 cycles", pci_rises, 4);
      chk(ref_rises == 24, "R5", "ref rises in 48 cycles", ref_rises, 24);
   endtask

   task automatic t_off();
      do_reset(2'b00);
      chk(clk_oe == 1'b0, "R6", "oe in off mode", int'(clk_oe), 0);
      run(PP * 2, "R6");
      chk(clk_oe == 1'b0, "R6", "oe stays low", int'(clk_oe), 0);
      chk(ref_rises == 2 * PP / RP, "R7", "ref rises off mode", ref_rises, 2 * PP / RP);
   endtask

   task automatic t_switch();
      do_reset(2'b01);
      run(5, "R9");
      mode_sel = 2'b11;
      // old ratio must hold until the wrap: 6 more cycles end the period
      clear_counts();
      run(PP - 6, "R9");
      chk(cpu_rises == 1 && pci_rises == 0, "R9", "old mode kept until wrap",
          cpu_rises * 10 + pci_rises, 10);
      run(PP * 2, "R9");
      mode_sel = 2'b10;
      run(PP + 5, "R9");
      mode_sel = 2'b00;
      run(PP * 2, "R9");
      mode_sel = 2'b01;
      run(PP * 2, "R9");
      // reset in the middle of a run
      do_reset(2'b11);
      run(PP, "R9");
   endtask

   initial begin
      t_low();
      t_high();
      t_test();
      t_off();
      t_switch();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule